// File: doc/BRIEF.md
# Pipelined No-Turnaround Static Memory with Posted Writes

This block is a synchronous word-wide memory built from four 9-bit byte lanes (36-bit words), with a parameterized address width. Every command (address plus controls) is registered on the rising clock edge. For a read, the word is driven on the data output two cycles after the command. For a write, the data is taken from the data input two cycles after the command. Because both directions use the same two-cycle offset, reads and writes can be interleaved on every cycle with no idle cycle between them.

Incoming writes are not written into the array at once. They are posted into a two-entry buffer. An entry reaches the array only when a newer write pushes it out, so the array always lags the two most recent writes. A read whose address matches pending writes gets the newest bytes lane by lane. The priority runs from the write data arriving in the same cycle, to the newer buffer entry, to the older buffer entry, and finally to the array. A built-in two-bit burst counter lets advance cycles continue a read or write burst. Other controls are a clock-enable stall, an asynchronous output enable and a snooze input. The data bus is split into an input, an output and a drive-enable flag, where a low drive-enable flag stands for high impedance.

Top module: `zws_sram`

## Requirements
- R1: A read command sampled at the end of cycle N drives its word on `dq_out` with `dq_drive` high throughout cycle N+2, provided `oe_n` is low and the block is not in snooze.
- R2: The data of a write command sampled at the end of cycle N is sampled from `dq_in` at the end of cycle N+2. It enters a two-entry posted buffer, and the array receives an entry only when a later write displaces it.
- R3: A read returns the most recently written value of every lane. This includes a write whose data arrives on the same edge the read is served, and writes still in the buffer. A newer write beats an older one lane by lane.
- R4: A load command (`adv_ld` low) is selected only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. Otherwise it does nothing, and `dq_drive` is low in cycle N+2.
- R5: While `cke_n` is sampled high, the whole pipeline holds. A read being output keeps driving the same word. A write's data cycle leaves `dq_drive` low, and its data is taken at the next enabled edge.
- R6: On a write, `bw_n[i]` low writes lane i, which is bits [9i+8:9i]. With all four bits high the write is a no-operation and the stored word is unchanged.
- R7: `oe_n` gates `dq_drive` combinationally in the same cycle, without waiting for a clock edge.
- R8: Once `zz` has been sampled high at two consecutive edges, `dq_drive` is low. Commands sampled while `zz` is high do nothing. Stored contents and the held output word are kept.
- R9: An advance cycle (`adv_ld` high) repeats the previous load's type, ignoring `we_n` and the chip enables. It uses the next burst address: the low two bits are (base+k) mod 4 when `burst_lin`=1, or base XOR k when `burst_lin`=0. The upper bits stay the same, and `bw_n` is sampled on each cycle.
- R10: Synchronous active-low reset empties the pipeline, the buffer and the burst state. `dq_drive` is low after reset, and an advance cycle issued before any load does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Word address for load commands |
| adv_ld | input | 1 | 1 = advance burst, 0 = load new address |
| we_n | input | 1 | 0 = write, 1 = read (load cycles only) |
| bw_n | input | 4 | Active-low lane write enables |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| cke_n | input | 1 | Active-low clock enable; high stalls the pipeline |
| oe_n | input | 1 | Asynchronous active-low output enable |
| zz | input | 1 | Snooze request |
| burst_lin | input | 1 | 1 = linear burst order, 0 = interleaved |
| dq_in | input | 36 | Write data, two cycles after its command |
| dq_out | output | 36 | Read data |
| dq_drive | output | 1 | High when the block drives the data bus |

## Verification
The assertions assume the following about the inputs:
- `burst_lin` is held steady for the whole of a burst.
- Inputs settle well away from the rising edge.
- The stall and snooze properties rely on `cke_n` and `zz` being registered only at edges.

The stimulus respects these assumptions. It changes every input at the falling edge, and it alters `burst_lin` only between bursts. It toggles `oe_n` only mid-cycle, which shows its effect is asynchronous. Reads are issued only to addresses that have already been written, so every expected word is defined.

// File: rtl/zws_pkg.sv
// Shared types and helpers for the pipelined posted-write memory.
// Assumes a word made of LANES byte lanes of LANE_W bits each.
package zws_pkg;
    localparam int LANES    = 4;
    localparam int LANE_W   = 9;
    localparam int WORD_W   = LANES * LANE_W;
    localparam int WB_DEPTH = 2;
    localparam int BURST_W  = 2;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [LANES-1:0]  lane_t;

    // Replace the lanes of base selected by sel with those of upd.
    function automatic word_t lane_merge(word_t base, word_t upd, lane_t sel);
        word_t r;
        r = base;
        for (int i = 0; i < LANES; i++) begin
            if (sel[i]) r[i*LANE_W +: LANE_W] = upd[i*LANE_W +: LANE_W];
        end
        return r;
    endfunction
endpackage

// File: rtl/zws_burst_seq.sv
// Command decoder and two-bit burst address sequencer.
// A load captures the address and type. An advance repeats the stored type
// at the next address, in linear or interleaved order. A quiet (snooze)
// sample turns the command into a no-op. State moves only on enabled edges.
module zws_burst_seq
    import zws_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    input  logic              adv_ld,
    input  logic              we_n,
    input  logic              ce_ok,
    input  logic              quiet,
    input  logic              linear,
    input  logic [ADDR_W-1:0] addr,
    input  lane_t             bw_n,
    output op_e               op_o,
    output logic [ADDR_W-1:0] addr_o,
    output lane_t             mask_o
);
    logic [ADDR_W-1:0]  base_q, base_d;
    logic [BURST_W-1:0] cnt_q, cnt_d, low;
    op_e                kind_q, kind_d;

    // Decode the command of this cycle and the next burst state.
    always_comb begin
        mask_o = ~bw_n;
        if (!adv_ld) begin
            if (ce_ok && !quiet) op_o = we_n ? OP_READ : OP_WRITE;
            else                 op_o = OP_NONE;
            addr_o = addr;
            base_d = addr;
            cnt_d  = '0;
            kind_d = op_o;
            low    = addr[BURST_W-1:0];
        end else begin
            cnt_d  = cnt_q + 1'b1;
            low    = linear ? (base_q[BURST_W-1:0] + cnt_d)
                            : (base_q[BURST_W-1:0] ^ cnt_d);
            addr_o = {base_q[ADDR_W-1:BURST_W], low};
            base_d = base_q;
            kind_d = kind_q;
            op_o   = quiet ? OP_NONE : kind_q;
        end
    end

    // Hold the burst base, count and type between commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
            kind_q <= OP_NONE;
        end else if (step_en) begin
            base_q <= base_d;
            cnt_q  <= cnt_d;
            kind_q <= kind_d;
        end
    end

    // R9: an enabled advance within a live burst steps the counter by one.
    p_burst_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && adv_ld && kind_q != OP_NONE) |=> (cnt_q == $past(cnt_q) + 2'd1));
endmodule

// File: rtl/zws_write_buf.sv
// Two-entry posted write buffer with lane-wise forwarding lookup.
// Entry 0 is the newest. A push shifts entries toward the oldest slot and
// hands the displaced oldest entry to the array. Lookup merges matching
// entries oldest first, so newer lanes win.
module zws_write_buf
    import zws_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  lane_t             push_mask,
    input  word_t             push_data,
    input  logic [ADDR_W-1:0] look_addr,
    output word_t             fwd_data,
    output lane_t             fwd_hit,
    output logic              retire_en,
    output logic [ADDR_W-1:0] retire_addr,
    output lane_t             retire_mask,
    output word_t             retire_data
);
    logic              e_v    [WB_DEPTH];
    logic [ADDR_W-1:0] e_addr [WB_DEPTH];
    lane_t             e_mask [WB_DEPTH];
    word_t             e_data [WB_DEPTH];

    assign retire_en   = push && e_v[WB_DEPTH-1];
    assign retire_addr = e_addr[WB_DEPTH-1];
    assign retire_mask = e_mask[WB_DEPTH-1];
    assign retire_data = e_data[WB_DEPTH-1];

    // Merge all pending entries that match the lookup address, newest last.
    always_comb begin
        fwd_data = '0;
        fwd_hit  = '0;
        for (int i = WB_DEPTH-1; i >= 0; i--) begin
            if (e_v[i] && e_addr[i] == look_addr) begin
                fwd_data = lane_merge(fwd_data, e_data[i], e_mask[i]);
                fwd_hit  = fwd_hit | e_mask[i];
            end
        end
    end

    // Shift the buffer on every accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WB_DEPTH; i++) begin
                e_v[i]    <= 1'b0;
                e_addr[i] <= '0;
                e_mask[i] <= '0;
                e_data[i] <= '0;
            end
        end else if (push) begin
            for (int i = WB_DEPTH-1; i > 0; i--) begin
                e_v[i]    <= e_v[i-1];
                e_addr[i] <= e_addr[i-1];
                e_mask[i] <= e_mask[i-1];
                e_data[i] <= e_data[i-1];
            end
            e_v[0]    <= 1'b1;
            e_addr[0] <= push_addr;
            e_mask[0] <= push_mask;
            e_data[0] <= push_data;
        end
    end

    // R2: the buffer fills from the newest slot, so an old entry implies a new one.
    p_wb_fill_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        e_v[WB_DEPTH-1] |-> e_v[0]);
endmodule

// File: rtl/zws_array.sv
// Storage array with per-lane write strobes and an asynchronous read port.
// Contents are not reset.
module zws_array
    import zws_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  lane_t             wmask,
    input  word_t             wdata,
    input  logic [ADDR_W-1:0] raddr,
    output word_t             rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    word_t mem [DEPTH];

    assign rdata = mem[raddr];

    // Commit a retired buffer entry lane by lane.
    always_ff @(posedge clk) begin
        if (we) begin
            for (int i = 0; i < LANES; i++) begin
                if (wmask[i]) mem[waddr][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
            end
        end
    end
endmodule

// File: rtl/zws_sram.sv
// Top level: pipelined memory with a two-cycle offset on both reads and writes.
// Stage 1 holds the command for one cycle, during which a read is served into
// the output register. Stage 2 holds a write until its data arrives. Snooze
// takes effect after two sampled edges. oe_n gates the drive combinationally.
module zws_sram
    import zws_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              adv_ld,
    input  logic              we_n,
    input  logic [LANES-1:0]  bw_n,
    input  logic              ce1_n,
    input  logic              ce2,
    input  logic              ce3_n,
    input  logic              cke_n,
    input  logic              oe_n,
    input  logic              zz,
    input  logic              burst_lin,
    input  logic [WORD_W-1:0] dq_in,
    output logic [WORD_W-1:0] dq_out,
    output logic              dq_drive
);
    logic              en, ce_ok;
    op_e               cmd_op, s1_op, s2_op;
    logic [ADDR_W-1:0] cmd_addr, s1_addr, s2_addr;
    lane_t             cmd_mask, s1_mask, s2_mask;
    word_t             arr_rd, wb_fwd, rd_word, out_d;
    lane_t             wb_hit;
    logic              push, ret_en, out_v, zz_q1, zz_q2;
    logic [ADDR_W-1:0] ret_addr;
    lane_t             ret_mask;
    word_t             ret_data;

    assign en    = !cke_n;
    assign ce_ok = !ce1_n && ce2 && !ce3_n;

    zws_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .step_en(en), .adv_ld(adv_ld), .we_n(we_n),
        .ce_ok(ce_ok), .quiet(zz), .linear(burst_lin), .addr(addr), .bw_n(bw_n),
        .op_o(cmd_op), .addr_o(cmd_addr), .mask_o(cmd_mask)
    );

    // Advance the two command stages on enabled edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_op   <= OP_NONE;
            s1_addr <= '0;
            s1_mask <= '0;
            s2_op   <= OP_NONE;
            s2_addr <= '0;
            s2_mask <= '0;
        end else if (en) begin
            s1_op   <= cmd_op;
            s1_addr <= cmd_addr;
            s1_mask <= cmd_mask;
            s2_op   <= s1_op;
            s2_addr <= s1_addr;
            s2_mask <= s1_mask;
        end
    end

    assign push = en && (s2_op == OP_WRITE) && (s2_mask != '0);

    zws_write_buf #(.ADDR_W(ADDR_W)) u_wbuf (
        .clk(clk), .rst_n(rst_n), .push(push), .push_addr(s2_addr),
        .push_mask(s2_mask), .push_data(dq_in), .look_addr(s1_addr),
        .fwd_data(wb_fwd), .fwd_hit(wb_hit), .retire_en(ret_en),
        .retire_addr(ret_addr), .retire_mask(ret_mask), .retire_data(ret_data)
    );

    zws_array #(.ADDR_W(ADDR_W)) u_arr (
        .clk(clk), .we(ret_en), .waddr(ret_addr), .wmask(ret_mask),
        .wdata(ret_data), .raddr(s1_addr), .rdata(arr_rd)
    );

    // Build the read word: array, then buffer, then write data arriving now.
    always_comb begin
        rd_word = lane_merge(arr_rd, wb_fwd, wb_hit);
        if (s2_op == OP_WRITE && s2_addr == s1_addr)
            rd_word = lane_merge(rd_word, dq_in, s2_mask);
    end

    // Output register: loads a served read, holds during a stall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_v <= 1'b0;
            out_d <= '0;
        end else if (en) begin
            out_v <= (s1_op == OP_READ);
            if (s1_op == OP_READ) out_d <= rd_word;
        end
    end

    // Two-edge snooze entry and exit delay.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zz_q1 <= 1'b0;
            zz_q2 <= 1'b0;
        end else begin
            zz_q1 <= zz;
            zz_q2 <= zz_q1;
        end
    end

    assign dq_out   = out_d;
    assign dq_drive = out_v && !oe_n && !zz_q2;

    // R5: a stalled edge leaves the output word and its valid flag untouched.
    p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cke_n |=> ($stable(dq_out) && $stable(out_v)));

    // R4: an unselected load, followed by an enabled edge, leaves the bus undriven.
    p_unsel_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !adv_ld && !ce_ok) ##1 en |=> !dq_drive);

    // R8: snooze sampled at two consecutive edges floats the bus.
    p_snooze_float_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (zz && $past(zz)) |=> !dq_drive);

    // R1: an enabled edge serving a read makes the output valid.
    p_read_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (en && s1_op == OP_READ) |=> out_v);
endmodule

// File: tb/tb_zws_sram.sv
module tb_zws_sram;
    import zws_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 6;

    localparam logic [2:0] K_IDLE = 3'd0;
    localparam logic [2:0] K_RD   = 3'd1;
    localparam logic [2:0] K_WR   = 3'd2;
    localparam logic [2:0] K_ADV  = 3'd3;
    localparam logic [2:0] K_CE2  = 3'd4;
    localparam logic [2:0] K_CE3  = 3'd5;

    // Vector fields: {kind, addr, bw_n, data}. Expected words come from the model.
    localparam int NV = 20;
    localparam logic [48:0] VEC [NV] = '{
        {K_WR,   6'h05, 4'h0, 36'h123456789},  // R2 full write
        {K_RD,   6'h05, 4'hF, 36'h0},          // R3 data arrives same edge
        {K_WR,   6'h05, 4'hE, 36'h0000000AA},  // R6 lane 0 only
        {K_RD,   6'h05, 4'hF, 36'h0},          // R3 merge over buffered word
        {K_WR,   6'h10, 4'h0, 36'hF0F0F0F0F},
        {K_WR,   6'h11, 4'h0, 36'h888888888},  // R2 retires older entries
        {K_RD,   6'h10, 4'hF, 36'h0},
        {K_RD,   6'h11, 4'hF, 36'h0},
        {K_RD,   6'h05, 4'hF, 36'h0},          // R2 word now from the array
        {K_WR,   6'h10, 4'h5, 36'h7FFFFFFFF},  // R6 lanes 1 and 3
        {K_RD,   6'h10, 4'hF, 36'h0},
        {K_IDLE, 6'h00, 4'hF, 36'h0},
        {K_WR,   6'h10, 4'hF, 36'h000000000},  // R6 no-op write
        {K_RD,   6'h10, 4'hF, 36'h0},
        {K_WR,   6'h12, 4'h0, 36'h111111111},
        {K_WR,   6'h12, 4'hC, 36'h0DEADBEEF},  // R3 newer lanes 0,1
        {K_RD,   6'h12, 4'hF, 36'h0},
        {K_CE2,  6'h10, 4'hF, 36'h0},          // R4
        {K_CE3,  6'h10, 4'hF, 36'h0},          // R4
        {K_RD,   6'h11, 4'hF, 36'h0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          adv_ld = 1'b0, we_n = 1'b1;
    logic [3:0]    bw_n = 4'hF;
    logic          ce1_n = 1'b1, ce2 = 1'b0, ce3_n = 1'b1;
    logic          cke_n = 1'b0, oe_n = 1'b0, zz = 1'b0, burst_lin = 1'b1;
    logic [35:0]   dq_in = '0;
    logic [35:0]   dq_out;
    logic          dq_drive;

    zws_sram #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .adv_ld(adv_ld), .we_n(we_n),
        .bw_n(bw_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .cke_n(cke_n),
        .oe_n(oe_n), .zz(zz), .burst_lin(burst_lin), .dq_in(dq_in),
        .dq_out(dq_out), .dq_drive(dq_drive)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    logic [35:0] mem [64];
    int          bm_kind = 0;
    logic [5:0]  bm_base = '0;
    logic [1:0]  bm_cnt = '0;
    bit          sl_rd [2];
    bit          sl_wr [2];
    logic [35:0] sl_exp [2];
    logic [35:0] sl_wd [2];
    string       sl_tag [2];

    task automatic chk(bit ok, string tag, string what, logic [35:0] act, logic [35:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [35:0] merge(logic [35:0] old, logic [35:0] nw, logic [3:0] bw);
        logic [35:0] r;
        r = old;
        for (int i = 0; i < 4; i++) if (!bw[i]) r[i*9 +: 9] = nw[i*9 +: 9];
        return r;
    endfunction

    function automatic string tag_of(logic [2:0] k);
        case (k)
            K_RD:    return "R3";
            K_WR:    return "R2";
            K_ADV:   return "R9";
            default: return "R4";
        endcase
    endfunction

    task automatic set_pins(logic [2:0] kind, logic [5:0] a, logic [3:0] bw);
        adv_ld = 1'b0; we_n = 1'b1; ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
        case (kind)
            K_IDLE: ce1_n = 1'b1;
            K_WR:   we_n = 1'b0;
            K_ADV:  begin adv_ld = 1'b1; ce1_n = 1'b1; end
            K_CE2:  ce2 = 1'b0;
            K_CE3:  ce3_n = 1'b1;
            default: ;
        endcase
        addr = a;
        bw_n = bw;
    endtask

    task automatic clear_slots();
        for (int i = 0; i < 2; i++) begin
            sl_rd[i] = 1'b0; sl_wr[i] = 1'b0; sl_tag[i] = "R4";
        end
    endtask

    // One pipelined cycle: check the command two cycles back, then drive a new one.
    task automatic step(logic [2:0] kind, logic [5:0] a, logic [3:0] bw,
                        logic [35:0] wd, string tag);
        int          ek;
        logic [5:0]  ea;
        @(negedge clk);
        if (sl_rd[1]) begin
            chk(dq_drive === 1'b1, sl_tag[1], "read drive", {35'd0, dq_drive}, 36'd1);
            chk(dq_out === sl_exp[1], sl_tag[1], "read data", dq_out, sl_exp[1]);
        end else begin
            chk(dq_drive === 1'b0, sl_tag[1], "bus idle", {35'd0, dq_drive}, 36'd0);
        end
        dq_in = sl_wr[1] ? sl_wd[1] : 36'h0BADBADBA;
        set_pins(kind, a, bw);
        if (kind == K_ADV) begin
            bm_cnt = bm_cnt + 2'd1;
            ea = {bm_base[5:2], burst_lin ? bm_base[1:0] + bm_cnt : bm_base[1:0] ^ bm_cnt};
            ek = bm_kind;
        end else begin
            ek = (kind == K_RD) ? 1 : (kind == K_WR) ? 2 : 0;
            bm_kind = ek; bm_base = a; bm_cnt = '0; ea = a;
        end
        sl_rd[1] = sl_rd[0]; sl_wr[1] = sl_wr[0];
        sl_exp[1] = sl_exp[0]; sl_wd[1] = sl_wd[0]; sl_tag[1] = sl_tag[0];
        sl_rd[0] = (ek == 1); sl_wr[0] = (ek == 2); sl_wd[0] = wd; sl_tag[0] = tag;
        if (ek == 2) mem[ea] = merge(mem[ea], wd, bw);
        sl_exp[0] = mem[ea];
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL R10 watchdog: actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [35:0] e;
        clear_slots();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R10: nothing driven after reset; a leading advance is a no-op.
        chk(dq_drive === 1'b0, "R10", "reset drive", {35'd0, dq_drive}, 36'd0);
        step(K_ADV, 6'h00, 4'h0, 36'h0, "R10");
        step(K_IDLE, 6'h00, 4'hF, 36'h0, "R10");
        step(K_IDLE, 6'h00, 4'hF, 36'h0, "R10");

        // Back-to-back read/write vector table (R1, R2, R3, R4, R6).
        for (int i = 0; i < NV; i++)
            step(VEC[i][48:46], VEC[i][45:40], VEC[i][39:36], VEC[i][35:0], tag_of(VEC[i][48:46]));
        step(K_IDLE, 6'h00, 4'hF, 36'h0, "R1");
        step(K_IDLE, 6'h00, 4'hF, 36'h0, "R1");

        // R9: linear write burst from 0x21, read back singly.
        burst_lin = 1'b1;
        step(K_WR,  6'h21, 4'h0, 36'hA00000001, "R9");
        step(K_ADV, 6'h00, 4'h0, 36'hA00000002, "R9");
        step(K_ADV, 6'h00, 4'h0, 36'hA00000003, "R9");
        step(K_ADV, 6'h00, 4'h0, 36'hA00000004, "R9");
        for (int i = 0; i < 4; i++) step(K_RD, 6'h20 + 6'(i), 4'hF, 36'h0, "R9");
        step(K_IDLE, 6'h00, 4'hF, 36'h0, "R9");
        // R9: interleaved write burst and read burst from 0x31.
        burst_lin = 1'b0;
        step(K_WR,  6'h31, 4'h0, 36'hB00000001, "R9");
        step(K_ADV, 6'h00, 4'h0, 36'hB00000002, "R9");
        step(K_ADV, 6'h00, 4'h0, 36'hB00000003, "R9");
        step(K_ADV, 6'h00, 4'h0, 36'hB00000004, "R9");
        step(K_RD,  6'h31, 4'hF, 36'h0, "R9");
        step(K_ADV, 6'h00, 4'hF, 36'h0, "R9");
        step(K_ADV, 6'h00, 4'hF, 36'h0, "R9");
        step(K_ADV, 6'h00, 4'hF, 36'h0, "R9");
        step(K_IDLE, 6'h00, 4'hF, 36'h0, "R9");
        step(K_IDLE, 6'h00, 4'hF, 36'h0, "R9");
        burst_lin = 1'b1;

        // R5 and R7: stalled read keeps driving; oe_n gates it at once.
        e = mem[6'h10];
        @(negedge clk) set_pins(K_RD, 6'h10, 4'hF);
        @(negedge clk) set_pins(K_IDLE, 6'h00, 4'hF);
        @(negedge clk) cke_n = 1'b1;
        chk(dq_drive === 1'b1, "R5", "stall read drive", {35'd0, dq_drive}, 36'd1);
        chk(dq_out === e, "R5", "stall read data", dq_out, e);
        @(negedge clk);
        chk(dq_out === e, "R5", "held data", dq_out, e);
        oe_n = 1'b1; #1;
        chk(dq_drive === 1'b0, "R7", "oe_n high", {35'd0, dq_drive}, 36'd0);
        oe_n = 1'b0; #1;
        chk(dq_drive === 1'b1, "R7", "oe_n low", {35'd0, dq_drive}, 36'd1);
        @(negedge clk) cke_n = 1'b0;
        chk(dq_out === e && dq_drive === 1'b1, "R5", "held after stall", dq_out, e);
        @(negedge clk);
        chk(dq_drive === 1'b0, "R5", "released", {35'd0, dq_drive}, 36'd0);

        // R5: stalled write data cycle floats the bus; data taken after release.
        @(negedge clk) set_pins(K_WR, 6'h13, 4'h0);
        @(negedge clk) set_pins(K_IDLE, 6'h00, 4'hF);
        @(negedge clk) begin cke_n = 1'b1; dq_in = 36'h5A5A5A5A5; end
        chk(dq_drive === 1'b0, "R5", "stall write float", {35'd0, dq_drive}, 36'd0);
        @(negedge clk) cke_n = 1'b0;
        chk(dq_drive === 1'b0, "R5", "write float", {35'd0, dq_drive}, 36'd0);
        @(negedge clk) dq_in = 36'h0BADBADBA;
        mem[6'h13] = 36'h5A5A5A5A5;
        clear_slots();
        step(K_RD, 6'h13, 4'hF, 36'h0, "R5");
        step(K_IDLE, 6'h00, 4'hF, 36'h0, "R5");
        step(K_IDLE, 6'h00, 4'hF, 36'h0, "R5");

        // R8: two-edge snooze entry, ignored command, retained contents.
        e = mem[6'h10];
        @(negedge clk) set_pins(K_RD, 6'h10, 4'hF);
        @(negedge clk) begin set_pins(K_IDLE, 6'h00, 4'hF); zz = 1'b1; end
        @(negedge clk) cke_n = 1'b1;
        chk(dq_drive === 1'b1 && dq_out === e, "R8", "one edge of snooze", dq_out, e);
        @(negedge clk);
        chk(dq_drive === 1'b0, "R8", "snooze float", {35'd0, dq_drive}, 36'd0);
        @(negedge clk) begin cke_n = 1'b0; set_pins(K_WR, 6'h10, 4'h0); end
        @(negedge clk) begin zz = 1'b0; set_pins(K_IDLE, 6'h00, 4'hF); end
        @(negedge clk) dq_in = 36'h055555555;
        chk(dq_drive === 1'b0, "R8", "ignored write", {35'd0, dq_drive}, 36'd0);
        @(negedge clk) dq_in = 36'h0BADBADBA;
        clear_slots();
        step(K_RD, 6'h10, 4'hF, 36'h0, "R8");
        step(K_IDLE, 6'h00, 4'hF, 36'h0, "R8");
        step(K_IDLE, 6'h00, 4'hF, 36'h0, "R8");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule